// File: doc/BRIEF.md
# Stereo Interleaved Morton Tile Sequencer

The block sets the order in which screen tiles go to the shader cores when both eye views of a stereo frame share one tiling pass. Within a view it walks the tile grid along a Z-curve: the bits of a running index are split so that the even bits form the tile column and the odd bits form the tile row. Each tile position is then covered in both views before the walk moves on. In left-right mode the left tile and the right tile at a position go out as two dispatches to the two cores of a core pair. In paired mode both tiles at a position go out as one job to a single core, and the cores take these jobs in turn.

A frame starts with a one-cycle `start` pulse, which also captures the grid size and the mode selection. A grid whose sides are not powers of two leaves gaps in the index space; those indices are passed over without a dispatch. Each dispatch waits for the ready line of the core it names. A one-cycle `done` follows the acceptance of the last tile. If the frame does not have exactly two views with a color-plus-depth target, the sequencer falls back to a plain single-view Z-curve walk. A 960x1080 view cut into 16x16 tiles gives a 60x68 grid, which the default widths cover.

Top module: `stereoTileSequencer`

## Requirements
- R1: Tile positions are visited in increasing index order, with tileX taken from index bits 0,2,4,... and tileY from bits 1,3,5,... (bit 0 of tileX is index bit 0), so every in-grid position is dispatched exactly once per view.
- R2: An index whose decoded column is not below gridW, or whose row is not below gridH, produces no dispatch. A dispatch never carries tileX >= gridW or tileY >= gridH.
- R3: With viewCount = 2, colorDepth = 1 and pairMode = 0 (left-right mode), each position is dispatched first with viewId = 0 (left), then with viewId = 1 (right) at the same tileX/tileY, before the next position. pairJob is 0.
- R4: In left-right mode, the left dispatch of the p-th position goes to core 2*(p mod NUM_CORES/2) and the right dispatch to the next core up. With two cores, left tiles go to core 0 and right tiles to core 1.
- R5: With viewCount = 2, colorDepth = 1 and pairMode = 1 (paired mode), each position is dispatched once with pairJob = 1 and viewId = 0. The k-th job of the frame goes to core k mod NUM_CORES.
- R6: When viewCount != 2 or colorDepth = 0, each position is dispatched once with viewId = 0 and pairJob = 0, whatever pairMode is. The k-th dispatch goes to core k mod NUM_CORES.
- R7: A dispatch is accepted only in a cycle where dispValid = 1 and coreReady[coreIdx] = 1. Until then tileX, tileY, viewId, pairJob and coreIdx stay unchanged. Ready lines of other cores have no effect.
- R8: done is high for exactly one cycle: the cycle after the last dispatch of position (gridW-1, gridH-1) is accepted. After that no dispatch is issued until the next start.
- R9: gridW, gridH, viewCount, colorDepth and pairMode are captured when start is seen while idle. A start pulse or an input change during a frame has no effect on that frame.
- R10: While reset (rstN = 0) is applied, and right after it, dispValid and done are 0.
- R11: A full 60x68 tile grid (a 960x1080 view in 16x16 tiles) is walked completely in left-right mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame start pulse, seen only while idle |
| gridW | input | COORD_W | Tile columns per view (1 or more) |
| gridH | input | COORD_W | Tile rows per view (1 or more) |
| viewCount | input | 2 | Number of views in the frame |
| colorDepth | input | 1 | 1 when the target holds color plus depth |
| pairMode | input | 1 | 0 = left-right dispatches, 1 = paired jobs |
| coreReady | input | NUM_CORES | Per-core ready |
| dispValid | output | 1 | A dispatch is offered |
| tileX | output | COORD_W | Tile column of the dispatch |
| tileY | output | COORD_W | Tile row of the dispatch |
| viewId | output | 1 | 0 = left, 1 = right |
| pairJob | output | 1 | Dispatch covers both views |
| coreIdx | output | CORE_W | Target core of the dispatch |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench uses grids with sides that are not powers of two, so a design that emitted gap indices or stopped at the wrong index would show extra or missing tiles. Ready is held back from the target core while other cores are ready. A design that accepted on the wrong ready line, or let coordinates drift during a stall, would then fail the per-dispatch comparison. A start pulse and changed inputs in the middle of a frame would expose a sequencer that restarts or takes up a new configuration. The single-tile grid and the full 60x68 grid test the end condition: a misplaced done pulse or a lost right-view tile would show there.

// File: rtl/stereoSeqPkg.sv
package stereoSeqPkg;

  typedef enum logic [1:0] {
    SEQ_MONO = 2'd0,
    SEQ_LR   = 2'd1,
    SEQ_PAIR = 2'd2
  } seqMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture configuration, clear walk
    logic step;       // move to next index
    logic advCore;    // position finished, rotate core pointer
    logic rightView;  // current dispatch is right view
  } seqStrobe_t;

endpackage

// File: rtl/stereoSeqPath.sv
module stereoSeqPath
  import stereoSeqPkg::*;
#(
  parameter int COORD_W   = 7,
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [COORD_W-1:0]   gridW,
  input  logic [COORD_W-1:0]   gridH,
  input  logic [1:0]           viewCount,
  input  logic                 colorDepth,
  input  logic                 pairMode,
  input  logic [NUM_CORES-1:0] coreReady,
  output seqMode_e             mode,
  output logic                 inGrid,
  output logic                 lastPos,
  output logic                 readySel,
  output logic [COORD_W-1:0]   tileX,
  output logic [COORD_W-1:0]   tileY,
  output logic [CORE_W-1:0]    coreIdx
);

  localparam int IDX_W = 2 * COORD_W;
  localparam int SUM_W = CORE_W + 2;

  logic [COORD_W-1:0] cfgW, cfgH;
  seqMode_e           cfgMode, loadMode;
  logic [IDX_W-1:0]   walkIdx;
  logic [CORE_W-1:0]  rrPtr, rrNext;
  logic [SUM_W-1:0]   rrSum, rrInc;

  assign loadMode = (viewCount == 2'd2 && colorDepth)
                    ? (pairMode ? SEQ_PAIR : SEQ_LR) : SEQ_MONO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgW    <= '0;
      cfgH    <= '0;
      cfgMode <= SEQ_MONO;
      walkIdx <= '0;
      rrPtr   <= '0;
    end else begin
      if (strobe.load) begin
        cfgW    <= gridW;
        cfgH    <= gridH;
        cfgMode <= loadMode;
        walkIdx <= '0;
        rrPtr   <= '0;
      end else begin
        if (strobe.step)    walkIdx <= walkIdx + IDX_W'(1);
        if (strobe.advCore) rrPtr   <= rrNext;
      end
    end
  end

  // de-interleave the Z-curve index
  for (genvar i = 0; i < COORD_W; i++) begin : g_split
    assign tileX[i] = walkIdx[2*i];
    assign tileY[i] = walkIdx[2*i+1];
  end

  assign inGrid  = (tileX < cfgW) && (tileY < cfgH);
  assign lastPos = (tileX == cfgW - COORD_W'(1)) && (tileY == cfgH - COORD_W'(1));
  assign mode    = cfgMode;

  // core rotation: pairs of cores in left-right mode, single cores otherwise
  assign rrInc  = (cfgMode == SEQ_LR) ? SUM_W'(2) : SUM_W'(1);
  assign rrSum  = SUM_W'(rrPtr) + rrInc;
  assign rrNext = (rrSum >= SUM_W'(NUM_CORES)) ? CORE_W'(rrSum - SUM_W'(NUM_CORES))
                                               : CORE_W'(rrSum);

  assign coreIdx  = (cfgMode == SEQ_LR) ? (rrPtr | CORE_W'(strobe.rightView)) : rrPtr;
  assign readySel = coreReady[coreIdx];

endmodule

// File: rtl/stereoSeqCtrl.sv
module stereoSeqCtrl
  import stereoSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqMode_e   mode,
  input  logic       inGrid,
  input  logic       lastPos,
  input  logic       readySel,
  output seqStrobe_t strobe,
  output logic       dispValid,
  output logic       viewId,
  output logic       pairJob,
  output logic       done
);

  logic running, rightPhase, doneQ;
  logic fire, posDone, finish;

  assign dispValid = running && inGrid;
  assign fire      = dispValid && readySel;
  assign posDone   = fire && (mode != SEQ_LR || rightPhase);
  assign finish    = posDone && lastPos;

  always_comb begin
    strobe.load      = !running && start;
    strobe.step      = running && (!inGrid || posDone) && !finish;
    strobe.advCore   = posDone;
    strobe.rightView = rightPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      rightPhase <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= finish;
      if (strobe.load) begin
        running    <= 1'b1;
        rightPhase <= 1'b0;
      end else begin
        if (finish) running <= 1'b0;
        if (fire && mode == SEQ_LR) rightPhase <= ~rightPhase;
      end
    end
  end

  assign viewId  = rightPhase;
  assign pairJob = (mode == SEQ_PAIR);
  assign done    = doneQ;

endmodule

// File: rtl/stereoTileSequencer.sv
module stereoTileSequencer
  import stereoSeqPkg::*;
#(
  parameter int COORD_W   = 7,
  parameter int NUM_CORES = 2,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [COORD_W-1:0]   gridW,
  input  logic [COORD_W-1:0]   gridH,
  input  logic [1:0]           viewCount,
  input  logic                 colorDepth,
  input  logic                 pairMode,
  input  logic [NUM_CORES-1:0] coreReady,
  output logic                 dispValid,
  output logic [COORD_W-1:0]   tileX,
  output logic [COORD_W-1:0]   tileY,
  output logic                 viewId,
  output logic                 pairJob,
  output logic [CORE_W-1:0]    coreIdx,
  output logic                 done
);

  seqStrobe_t strobe;
  seqMode_e   mode;
  logic       inGrid, lastPos, readySel;

  stereoSeqPath #(.COORD_W(COORD_W), .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .gridW(gridW), .gridH(gridH), .viewCount(viewCount),
    .colorDepth(colorDepth), .pairMode(pairMode), .coreReady(coreReady),
    .mode(mode), .inGrid(inGrid), .lastPos(lastPos), .readySel(readySel),
    .tileX(tileX), .tileY(tileY), .coreIdx(coreIdx)
  );

  stereoSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .inGrid(inGrid), .lastPos(lastPos), .readySel(readySel),
    .strobe(strobe), .dispValid(dispValid), .viewId(viewId),
    .pairJob(pairJob), .done(done)
  );

endmodule

// File: rtl/stereoTileSequencerChk.sv
module stereoTileSequencerChk #(
  parameter int COORD_W   = 7,
  parameter int NUM_CORES = 2,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] coreReady,
  input logic                 dispValid,
  input logic [COORD_W-1:0]   tileX,
  input logic [COORD_W-1:0]   tileY,
  input logic                 viewId,
  input logic                 pairJob,
  input logic [CORE_W-1:0]    coreIdx,
  input logic                 done
);

  logic [COORD_W-1:0] leftX, leftY;
  logic               accept;

  assign accept = dispValid && coreReady[coreIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftX <= '0;
      leftY <= '0;
    end else if (accept && !viewId) begin
      leftX <= tileX;
      leftY <= tileY;
    end
  end

  // R10: quiet under reset
  always @(posedge clk) begin
    if (!rstN) a_r10_reset_quiet: assert (!dispValid && !done);
  end

  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && !coreReady[coreIdx] |=> dispValid && $stable(tileX) && $stable(tileY)
      && $stable(viewId) && $stable(pairJob) && $stable(coreIdx));

  a_r3_right_same_pos: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && viewId |-> tileX == leftX && tileY == leftY);

  a_r4_right_odd_core: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && viewId |-> coreIdx[0]);

  a_r5_pair_is_left: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && pairJob |-> !viewId);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !dispValid);

endmodule

bind stereoTileSequencer stereoTileSequencerChk #(.COORD_W(COORD_W), .NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rstN(rstN), .coreReady(coreReady), .dispValid(dispValid),
  .tileX(tileX), .tileY(tileY), .viewId(viewId), .pairJob(pairJob),
  .coreIdx(coreIdx), .done(done)
);

// File: tb/stereoTileSequencer_test.sv
module stereoTileSequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 7;
  localparam int NC = 2;
  localparam int CRW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] gridW = '0, gridH = '0;
  logic [1:0]    viewCount = 2'd2;
  logic          colorDepth = 1'b1;
  logic          pairMode = 1'b0;
  logic [NC-1:0] coreReady = '0;
  logic          dispValid, viewId, pairJob, done;
  logic [CW-1:0] tileX, tileY;
  logic [CRW-1:0] coreIdx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  stereoTileSequencer #(.COORD_W(CW), .NUM_CORES(NC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .gridW(gridW), .gridH(gridH),
    .viewCount(viewCount), .colorDepth(colorDepth), .pairMode(pairMode),
    .coreReady(coreReady), .dispValid(dispValid), .tileX(tileX), .tileY(tileY),
    .viewId(viewId), .pairJob(pairJob), .coreIdx(coreIdx), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int colOf(int m);
    int r = 0;
    for (int i = 0; i < CW; i++) r |= ((m >> (2*i)) & 1) << i;
    return r;
  endfunction

  function automatic int rowOf(int m);
    int r = 0;
    for (int i = 0; i < CW; i++) r |= ((m >> (2*i+1)) & 1) << i;
    return r;
  endfunction

  function automatic int nextPos(int from, int w, int h);
    for (int m = from; m < (1 << (2*CW)); m++)
      if (colOf(m) < w && rowOf(m) < h) return m;
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    start = 1'b1;
    coreReady = '1;
    repeat (3) @(negedge clk);
    check("R10", dispValid, 0, "dispValid in reset");
    check("R10", done, 0, "done in reset");
    start = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R10", dispValid, 0, "dispValid after reset");
    check("R10", done, 0, "done after reset");
  endtask

  // modeExp: 0 mono (R6), 1 left-right (R3/R4), 2 paired (R5)
  // stall=1: target core refused twice per dispatch while others are ready (R7)
  // midStart=1: start pulse and changed inputs during the frame (R9)
  task automatic runFrame(string tag, int w, int h, int vc, int cd, int pm,
                          int stall, int midStart);
    int modeExp, m, ph, k, pos, wait_, tries, accepts;
    bit endSeen, expectDone, midDone;
    modeExp = (vc == 2 && cd == 1) ? (pm ? 2 : 1) : 0;
    gridW = CW'(w); gridH = CW'(h);
    viewCount = 2'(vc); colorDepth = cd[0]; pairMode = pm[0];
    coreReady = '1;
    @(negedge clk);
    start = 1'b1;
    m = nextPos(0, w, h); ph = 0; k = 0; pos = 0; wait_ = 0; tries = 0;
    accepts = 0; endSeen = 0; expectDone = 0; midDone = 0;
    while (!endSeen && tries < 40000) begin
      @(negedge clk);
      tries++;
      start = 1'b0;
      if (midStart && accepts == 3 && !midDone) begin
        start = 1'b1;
        gridW = CW'(2); gridH = CW'(2);
        pairMode = ~pairMode; viewCount = 2'd1;
        midDone = 1;
      end
      if (expectDone) begin
        check("R8", done, 1, "done after last accept");
        check("R8", dispValid, 0, "no dispatch with done");
        endSeen = 1;
      end else begin
        checks++;
        if (done) begin
          errors++;
          $display("FAIL R8: early done actual 1 expected 0 at position %0d", pos);
        end
        if (dispValid) begin
          int ex, ey, ev, ep, ec;
          ex = colOf(m); ey = rowOf(m);
          ev = (modeExp == 1) ? ph : 0;
          ep = (modeExp == 2) ? 1 : 0;
          ec = (modeExp == 1) ? 2 * (pos % (NC/2)) + ph : k % NC;
          checks++;
          if (tileX != CW'(ex) || tileY != CW'(ey) || viewId != ev[0] ||
              pairJob != ep[0] || int'(coreIdx) != ec) begin
            errors++;
            $display("FAIL %s (R1/R3/R5/R6%s): x,y,view,pair,core actual %0d,%0d,%0d,%0d,%0d expected %0d,%0d,%0d,%0d,%0d",
                     tag, stall ? " R7" : "", tileX, tileY, viewId, pairJob, coreIdx,
                     ex, ey, ev, ep, ec);
          end
          if (tileX >= gridW && !midDone) begin
            errors++;
            $display("FAIL R2: column outside grid actual %0d expected < %0d", tileX, w);
          end
          if (stall && wait_ < 2) begin
            coreReady = ~(NC'(1) << ec);
            wait_++;
          end else begin
            coreReady = '1;
            wait_ = 0;
            accepts++;
            k++;
            if (modeExp == 1 && ph == 0) ph = 1;
            else begin
              ph = 0;
              pos++;
              if (ex == w - 1 && ey == h - 1) expectDone = 1;
              else m = nextPos(m + 1, w, h);
            end
          end
        end else begin
          coreReady = '1;
        end
      end
    end
    if (!endSeen) begin
      errors++;
      $display("FAIL %s R8: frame not finished, actual %0d cycles expected fewer", tag, tries);
    end
    check(tag, pos, w * h, "positions covered (R1)");
    repeat (2) begin
      @(negedge clk);
      check("R8", dispValid, 0, "idle after done");
      check("R8", done, 0, "done width one cycle");
    end
  endtask

  task automatic testLeftRight();     runFrame("R3", 4, 4, 2, 1, 0, 0, 0); endtask
  task automatic testLeftRightCore(); runFrame("R4", 3, 5, 2, 1, 0, 0, 0); endtask
  task automatic testGapSkip();       runFrame("R2", 3, 5, 2, 1, 0, 1, 0); endtask
  task automatic testPaired();        runFrame("R5", 5, 3, 2, 1, 1, 0, 0); endtask
  task automatic testPairedStall();   runFrame("R7", 6, 7, 2, 1, 1, 1, 0); endtask
  task automatic testMonoViews();     runFrame("R6", 5, 6, 1, 1, 1, 0, 0); endtask
  task automatic testMonoNoDepth();   runFrame("R6", 7, 3, 2, 0, 1, 1, 0); endtask
  task automatic testMidStart();      runFrame("R9", 5, 5, 2, 1, 0, 0, 1); endtask
  task automatic testSingleTile();    runFrame("R8", 1, 1, 2, 1, 1, 0, 0); endtask
  task automatic testFullView();      runFrame("R11", 60, 68, 2, 1, 0, 0, 0); endtask

  initial begin
    doReset();
    testLeftRight();
    testLeftRightCore();
    testGapSkip();
    testPaired();
    testPairedStall();
    testMonoViews();
    testMonoNoDepth();
    testMidStart();
    testSingleTile();
    testFullView();
    doReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule